// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block runs the byte-level flow of an I2C master transfer. Software or neighbouring logic drives it with one-cycle task pulses (start-transmit, start-receive, stop, suspend, resume). The block answers with one-cycle event pulses (transmit started, receive started, last transmit byte, last receive byte, suspended, stopped, error). It orders a bit-level engine to produce START, STOP, byte-write and byte-read operations. It reads the bytes it sends from a buffer channel by index and writes the bytes it receives back by index.

A transfer never ends by itself. When the byte limit is reached, or after a NACK, the sequencer parks at a byte boundary with the clock held low and waits for a stop task. Five shortcut enables can feed the last-byte events straight back in as tasks. With them a write-then-read transfer, including its repeated START, can run without software taking part. Two sticky flags record whether a NACK followed the address or a data byte. Writing a 1 to a flag clears it.

Top module: `twi_txn_seq`

## Requirements
- R1: A start-transmit task while idle makes the engine issue START (cmd_op 0), then a write (cmd_op 2) of the byte {cfg_addr, 0}, and pulses ev_tx_started once. A start-receive task does the same with the byte {cfg_addr, 1} and pulses ev_rx_started.
- R2: ev_last_tx pulses exactly once per transmit, when the write of data byte tx_limit-1 is issued. At that moment tx_limit+1 engine completions (START, address, tx_limit-1 bytes) have passed. Data byte i is read from buffer index i.
- R3: ev_last_rx pulses exactly once per receive, after rx_limit+1 engine completions. For rx_limit 1 this is right after the address acknowledge. Otherwise it is right after the read of byte rx_limit-2 completes.
- R4: Each receive read (cmd_op 3) drives cmd_nack_out 0 (ACK), except the final read, which drives 1 (NACK). Received byte i is written to buffer index i.
- R5: After the last byte the block issues no STOP without a stop task and holds hold_scl high. A stop task then issues STOP (cmd_op 1) and pulses ev_stopped when STOP completes.
- R6: A suspend task lets the current byte finish, then raises hold_scl, pulses ev_suspended and issues no commands. A resume task continues with the next byte.
- R7: A stop task that arrives while suspended has no effect. The transfer resumes with its remaining bytes after resume.
- R8: cfg_shorts bit 0 routes last-tx to start-receive, bit 1 last-tx to suspend, bit 2 last-tx to stop, bit 3 last-rx to start-transmit, and bit 4 last-rx to stop. A start task during an active transfer produces a repeated START at the next byte boundary.
- R9: A NACK (eng_nack 1) after the address or after a data byte pulses ev_error, sets addr_nack_flag or data_nack_flag respectively, and stops data transfer. Each flag stays set until a 1 is written on its clear input.
- R10: A start task that arrives while a stop is pending, or in the same cycle as a stop task, is ignored: no repeated START and no started event follow.
- R11: After reset all event outputs, cmd_valid, hold_scl and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_start_tx | input | 1 | Start-transmit task pulse |
| task_start_rx | input | 1 | Start-receive task pulse |
| task_stop | input | 1 | Stop task pulse |
| task_suspend | input | 1 | Suspend task pulse |
| task_resume | input | 1 | Resume task pulse |
| cfg_addr | input | 7 | Target device address |
| cfg_shorts | input | 5 | Event-to-task shortcut enables |
| tx_limit | input | 8 | Bytes to send |
| rx_limit | input | 8 | Bytes to receive |
| clr_addr_nack | input | 1 | Write-1 clear of the address-NACK flag |
| clr_data_nack | input | 1 | Write-1 clear of the data-NACK flag |
| ev_tx_started | output | 1 | Transmit started event |
| ev_rx_started | output | 1 | Receive started event |
| ev_last_tx | output | 1 | Final transmit byte begins |
| ev_last_rx | output | 1 | Final receive byte begins |
| ev_suspended | output | 1 | Suspension took effect |
| ev_stopped | output | 1 | STOP completed |
| ev_error | output | 1 | NACK received |
| addr_nack_flag | output | 1 | Sticky address-NACK flag |
| data_nack_flag | output | 1 | Sticky data-NACK flag |
| cmd_valid | output | 1 | Engine command strobe |
| cmd_op | output | 2 | 0 START, 1 STOP, 2 write, 3 read |
| cmd_byte | output | 8 | Byte to write |
| cmd_nack_out | output | 1 | Acknowledge bit to drive on a read (1 = NACK) |
| eng_done | input | 1 | Engine finished the command |
| eng_nack | input | 1 | Acknowledge bit sampled on a write (1 = NACK) |
| eng_rdata | input | 8 | Byte read by the engine |
| hold_scl | output | 1 | Engine keeps SCL low at a byte boundary |
| buf_rd_idx | output | 8 | Index of the byte to send |
| buf_rd_data | input | 8 | Byte to send, combinational from index |
| buf_wr_en | output | 1 | Store a received byte |
| buf_wr_idx | output | 8 | Index of the received byte |
| buf_wr_data | output | 8 | Received byte |

## Verification
Engine commands appear in the same cycle the sequencer enters a command state. The bench's engine model returns its completion four cycles after it samples the strobe. Every event output is registered, so it appears one cycle after its cause, and a shortcut task takes effect one cycle after that. The bench therefore never checks a last-byte event by absolute time. Instead it records how many engine completions had been counted when the event was sampled, and compares that with limit+1. Suspend, ignored-stop and no-self-stop checks wait tens of cycles, several full command latencies, before they sample the command log, so a late or missing command cannot slip past.

// File: rtl/twi_seq_pkg.sv
package twi_seq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } twi_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_ADDR,
    S_TXB,
    S_RXB,
    S_HOLD,
    S_SUSP,
    S_STOP
  } seq_state_e;

  // shortcut enable positions
  localparam int SC_TX2RX   = 0;
  localparam int SC_TX2SUSP = 1;
  localparam int SC_TX2STOP = 2;
  localparam int SC_RX2TX   = 3;
  localparam int SC_RX2STOP = 4;
  localparam int SC_N       = 5;

  // event vector positions
  localparam int EV_TXS  = 0;
  localparam int EV_RXS  = 1;
  localparam int EV_LTX  = 2;
  localparam int EV_LRX  = 3;
  localparam int EV_SUSP = 4;
  localparam int EV_STOP = 5;
  localparam int EV_ERR  = 6;
  localparam int EV_N    = 7;

endpackage

// File: rtl/twi_seq_shortcut.sv
module twi_seq_shortcut
  import twi_seq_pkg::*;
(
  input  logic [SC_N-1:0] shorts,
  input  logic            ev_last_tx,
  input  logic            ev_last_rx,
  input  logic            t_start_tx,
  input  logic            t_start_rx,
  input  logic            t_stop,
  input  logic            t_suspend,
  output logic            e_start_tx,
  output logic            e_start_rx,
  output logic            e_stop,
  output logic            e_suspend
);

  assign e_start_rx = t_start_rx | (ev_last_tx & shorts[SC_TX2RX]);
  assign e_suspend  = t_suspend  | (ev_last_tx & shorts[SC_TX2SUSP]);
  assign e_start_tx = t_start_tx | (ev_last_rx & shorts[SC_RX2TX]);
  assign e_stop     = t_stop     | (ev_last_tx & shorts[SC_TX2STOP])
                                 | (ev_last_rx & shorts[SC_RX2STOP]);

endmodule

// File: rtl/twi_seq_pending.sv
module twi_seq_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic in_susp,
  input  logic in_stop,
  input  logic set_stop,
  input  logic set_susp,
  input  logic set_stx,
  input  logic set_srx,
  input  logic clr_susp,
  input  logic clr_restart,
  input  logic clr_all,
  output logic stop_now,
  output logic susp_now,
  output logic restart_now,
  output logic restart_rx
);

  logic stop_q, susp_q, rs_q, rs_dir_q;
  logic stop_set, susp_set, rs_set;
  logic stop_d, susp_d, rs_d;

  // a stop while suspended is dropped; starts behind a stop are dropped
  assign stop_set = set_stop & active & ~in_susp & ~in_stop;
  assign susp_set = set_susp & active & ~in_susp & ~in_stop;
  assign stop_now = stop_q | stop_set;
  assign rs_set   = (set_stx | set_srx) & active & ~in_susp & ~in_stop & ~stop_now;
  assign susp_now    = susp_q | susp_set;
  assign restart_now = rs_q | rs_set;
  assign restart_rx  = rs_set ? set_srx : rs_dir_q;

  always_comb begin
    stop_d = clr_all ? 1'b0 : stop_now;
    susp_d = (clr_all | clr_susp) ? 1'b0 : susp_now;
    rs_d   = (clr_all | clr_restart) ? 1'b0 : restart_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q   <= 1'b0;
      susp_q   <= 1'b0;
      rs_q     <= 1'b0;
      rs_dir_q <= 1'b0;
    end else begin
      stop_q <= stop_d;
      susp_q <= susp_d;
      rs_q   <= rs_d;
      if (rs_set) rs_dir_q <= set_srx;
    end
  end

endmodule

// File: rtl/twi_seq_errflags.sv
module twi_seq_errflags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_addr,
  input  logic set_data,
  input  logic clr_addr,
  input  logic clr_data,
  output logic addr_flag,
  output logic data_flag
);

  logic a_d, d_d;

  // a new NACK wins over a clear in the same cycle
  always_comb begin
    a_d = set_addr | (addr_flag & ~clr_addr);
    d_d = set_data | (data_flag & ~clr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_flag <= 1'b0;
      data_flag <= 1'b0;
    end else begin
      addr_flag <= a_d;
      data_flag <= d_d;
    end
  end

endmodule

// File: rtl/twi_txn_seq.sv
module twi_txn_seq
  import twi_seq_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                task_start_tx,
  input  logic                task_start_rx,
  input  logic                task_stop,
  input  logic                task_suspend,
  input  logic                task_resume,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [SC_N-1:0]     cfg_shorts,
  input  logic [CNT_W-1:0]    tx_limit,
  input  logic [CNT_W-1:0]    rx_limit,
  input  logic                clr_addr_nack,
  input  logic                clr_data_nack,
  output logic                ev_tx_started,
  output logic                ev_rx_started,
  output logic                ev_last_tx,
  output logic                ev_last_rx,
  output logic                ev_suspended,
  output logic                ev_stopped,
  output logic                ev_error,
  output logic                addr_nack_flag,
  output logic                data_nack_flag,
  output logic                cmd_valid,
  output logic [1:0]          cmd_op,
  output logic [ADDR_W:0]     cmd_byte,
  output logic                cmd_nack_out,
  input  logic                eng_done,
  input  logic                eng_nack,
  input  logic [ADDR_W:0]     eng_rdata,
  output logic                hold_scl,
  output logic [CNT_W-1:0]    buf_rd_idx,
  input  logic [ADDR_W:0]     buf_rd_data,
  output logic                buf_wr_en,
  output logic [CNT_W-1:0]    buf_wr_idx,
  output logic [ADDR_W:0]     buf_wr_data
);

  localparam int CW1 = CNT_W + 1;

  seq_state_e       state_q, state_n;
  logic             wait_q, wait_n;
  logic             dir_q, dir_n;
  logic             halt_q, halt_n;
  logic [CW1-1:0]   cnt_q, cnt_n;
  logic [EV_N-1:0]  ev_q, ev_n;

  logic e_stx, e_srx, e_stop, e_susp;
  logic stop_now, susp_now, restart_now, restart_rx;
  logic clr_susp, clr_rs, clr_all, set_an, set_dn, bnd;
  logic [CW1-1:0] cnt_p1, cnt_p2, txl, rxl;
  twi_op_e op_c;

  assign cnt_p1 = cnt_q + CW1'(1);
  assign cnt_p2 = cnt_q + CW1'(2);
  assign txl    = CW1'(tx_limit);
  assign rxl    = CW1'(rx_limit);

  twi_seq_shortcut u_short (
    .shorts     (cfg_shorts),
    .ev_last_tx (ev_q[EV_LTX]),
    .ev_last_rx (ev_q[EV_LRX]),
    .t_start_tx (task_start_tx),
    .t_start_rx (task_start_rx),
    .t_stop     (task_stop),
    .t_suspend  (task_suspend),
    .e_start_tx (e_stx),
    .e_start_rx (e_srx),
    .e_stop     (e_stop),
    .e_suspend  (e_susp)
  );

  twi_seq_pending u_pend (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (state_q != S_IDLE),
    .in_susp     (state_q == S_SUSP),
    .in_stop     (state_q == S_STOP),
    .set_stop    (e_stop),
    .set_susp    (e_susp),
    .set_stx     (e_stx),
    .set_srx     (e_srx),
    .clr_susp    (clr_susp),
    .clr_restart (clr_rs),
    .clr_all     (clr_all),
    .stop_now    (stop_now),
    .susp_now    (susp_now),
    .restart_now (restart_now),
    .restart_rx  (restart_rx)
  );

  twi_seq_errflags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_addr  (set_an),
    .set_data  (set_dn),
    .clr_addr  (clr_addr_nack),
    .clr_data  (clr_data_nack),
    .addr_flag (addr_nack_flag),
    .data_flag (data_nack_flag)
  );

  // next-state logic
  always_comb begin
    state_n  = state_q;
    wait_n   = wait_q;
    dir_n    = dir_q;
    halt_n   = halt_q;
    cnt_n    = cnt_q;
    ev_n     = '0;
    cmd_valid    = 1'b0;
    op_c         = OP_START;
    cmd_byte     = '0;
    cmd_nack_out = 1'b0;
    buf_wr_en    = 1'b0;
    bnd      = 1'b0;
    clr_susp = 1'b0;
    clr_rs   = 1'b0;
    clr_all  = 1'b0;
    set_an   = 1'b0;
    set_dn   = 1'b0;

    case (state_q)
      S_IDLE: begin
        if (e_stx | e_srx) begin
          state_n = S_START;
          dir_n   = e_srx;
          cnt_n   = '0;
          halt_n  = 1'b0;
          wait_n  = 1'b0;
        end
      end
      S_START: begin
        if (!wait_q) begin
          cmd_valid = 1'b1;
          op_c      = OP_START;
          wait_n    = 1'b1;
          if (dir_q) ev_n[EV_RXS] = 1'b1;
          else       ev_n[EV_TXS] = 1'b1;
        end else if (eng_done) begin
          wait_n  = 1'b0;
          state_n = S_ADDR;
        end
      end
      S_ADDR: begin
        if (!wait_q) begin
          cmd_valid = 1'b1;
          op_c      = OP_WRITE;
          cmd_byte  = {cfg_addr, dir_q};
          wait_n    = 1'b1;
        end else if (eng_done) begin
          if (eng_nack) begin
            ev_n[EV_ERR] = 1'b1;
            set_an       = 1'b1;
            halt_n       = 1'b1;
          end else if (dir_q && (rxl == CW1'(1))) begin
            ev_n[EV_LRX] = 1'b1;
          end
          bnd = 1'b1;
        end
      end
      S_TXB: begin
        if (!wait_q) begin
          cmd_valid = 1'b1;
          op_c      = OP_WRITE;
          cmd_byte  = buf_rd_data;
          wait_n    = 1'b1;
          if (cnt_p1 == txl) ev_n[EV_LTX] = 1'b1;
        end else if (eng_done) begin
          cnt_n = cnt_p1;
          if (eng_nack) begin
            ev_n[EV_ERR] = 1'b1;
            set_dn       = 1'b1;
            halt_n       = 1'b1;
          end
          bnd = 1'b1;
        end
      end
      S_RXB: begin
        if (!wait_q) begin
          cmd_valid    = 1'b1;
          op_c         = OP_READ;
          cmd_nack_out = (cnt_p1 == rxl);
          wait_n       = 1'b1;
        end else if (eng_done) begin
          buf_wr_en = 1'b1;
          cnt_n     = cnt_p1;
          if (cnt_p2 == rxl) ev_n[EV_LRX] = 1'b1;
          bnd = 1'b1;
        end
      end
      S_HOLD: bnd = 1'b1;
      S_SUSP: if (task_resume) bnd = 1'b1;
      S_STOP: begin
        if (!wait_q) begin
          cmd_valid = 1'b1;
          op_c      = OP_STOP;
          wait_n    = 1'b1;
        end else if (eng_done) begin
          wait_n        = 1'b0;
          ev_n[EV_STOP] = 1'b1;
          clr_all       = 1'b1;
          state_n       = S_IDLE;
        end
      end
      default: state_n = S_IDLE;
    endcase

    // byte-boundary decision: suspend, stop, repeated start, more data, park
    if (bnd) begin
      wait_n = 1'b0;
      if (susp_now) begin
        state_n       = S_SUSP;
        ev_n[EV_SUSP] = 1'b1;
        clr_susp      = 1'b1;
      end else if (stop_now) begin
        state_n = S_STOP;
      end else if (restart_now) begin
        state_n = S_START;
        dir_n   = restart_rx;
        cnt_n   = '0;
        halt_n  = 1'b0;
        clr_rs  = 1'b1;
      end else if (!halt_n && !dir_q && (cnt_n < txl)) begin
        state_n = S_TXB;
      end else if (!halt_n && dir_q && (cnt_n < rxl)) begin
        state_n = S_RXB;
      end else begin
        state_n = S_HOLD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      wait_q  <= 1'b0;
      dir_q   <= 1'b0;
      halt_q  <= 1'b0;
      cnt_q   <= '0;
      ev_q    <= '0;
    end else begin
      state_q <= state_n;
      wait_q  <= wait_n;
      dir_q   <= dir_n;
      halt_q  <= halt_n;
      cnt_q   <= cnt_n;
      ev_q    <= ev_n;
    end
  end

  assign cmd_op        = op_c;
  assign hold_scl      = (state_q == S_SUSP) || (state_q == S_HOLD);
  assign buf_rd_idx    = cnt_q[CNT_W-1:0];
  assign buf_wr_idx    = cnt_q[CNT_W-1:0];
  assign buf_wr_data   = eng_rdata;
  assign ev_tx_started = ev_q[EV_TXS];
  assign ev_rx_started = ev_q[EV_RXS];
  assign ev_last_tx    = ev_q[EV_LTX];
  assign ev_last_rx    = ev_q[EV_LRX];
  assign ev_suspended  = ev_q[EV_SUSP];
  assign ev_stopped    = ev_q[EV_STOP];
  assign ev_error      = ev_q[EV_ERR];

endmodule

// File: rtl/twi_txn_seq_chk.sv
module twi_txn_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ev_tx_started,
  input logic ev_rx_started,
  input logic ev_suspended,
  input logic ev_stopped,
  input logic ev_error,
  input logic addr_nack_flag,
  input logic data_nack_flag,
  input logic cmd_valid,
  input logic hold_scl,
  input logic eng_done,
  input logic eng_nack
);

  // R6: a suspension event coincides with the clock being held
  assert_susp_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_suspended |-> hold_scl);

  // R5: no engine command is issued while the clock is parked
  assert_no_cmd_parked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_scl |-> !cmd_valid);

  // R5: stopped follows an engine completion
  assert_stop_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stopped |-> $past(eng_done));

  // R9: error only after a sampled NACK
  assert_err_after_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_error |-> $past(eng_done && eng_nack));

  // R9: flags rise only on a NACK
  assert_aflag_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_nack_flag) |-> $past(eng_done && eng_nack));
  assert_dflag_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_nack_flag) |-> $past(eng_done && eng_nack));

  // R1: a start is either transmit or receive, never both
  assert_one_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_tx_started, ev_rx_started}));

  // R1: each command is a single-cycle strobe
  assert_cmd_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

endmodule

bind twi_txn_seq twi_txn_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ev_tx_started  (ev_tx_started),
  .ev_rx_started  (ev_rx_started),
  .ev_suspended   (ev_suspended),
  .ev_stopped     (ev_stopped),
  .ev_error       (ev_error),
  .addr_nack_flag (addr_nack_flag),
  .data_nack_flag (data_nack_flag),
  .cmd_valid      (cmd_valid),
  .hold_scl       (hold_scl),
  .eng_done       (eng_done),
  .eng_nack       (eng_nack)
);

// File: tb/twi_txn_seq_tb.sv
module twi_txn_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] TADDR = 7'h5A;
  localparam int OPS = 0, OPP = 1, OPW = 2, OPR = 3;

  // vector: [15] receive, [14:8] limit, [4:0] shortcuts
  localparam logic [15:0] VEC [4] = '{
    {1'b0, 7'd1, 3'b000, 5'b00100},
    {1'b0, 7'd3, 3'b000, 5'b00100},
    {1'b1, 7'd1, 3'b000, 5'b10000},
    {1'b1, 7'd4, 3'b000, 5'b10000}
  };

  logic clk, rst_n;
  logic t_stx, t_srx, t_stop, t_susp, t_res;
  logic [6:0] cfg_addr;
  logic [4:0] cfg_shorts;
  logic [7:0] tx_limit, rx_limit;
  logic clr_a, clr_d;
  logic ev_txs, ev_rxs, ev_ltx, ev_lrx, ev_susp, ev_stop, ev_err;
  logic fa, fd, cmd_valid, cmd_nack_out, hold_scl, buf_wr_en;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte, buf_rd_idx, buf_rd_data, buf_wr_idx, buf_wr_data;
  logic eng_done, eng_nack;
  logic [7:0] eng_rdata;

  twi_txn_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .task_start_tx(t_stx), .task_start_rx(t_srx), .task_stop(t_stop),
    .task_suspend(t_susp), .task_resume(t_res),
    .cfg_addr(cfg_addr), .cfg_shorts(cfg_shorts),
    .tx_limit(tx_limit), .rx_limit(rx_limit),
    .clr_addr_nack(clr_a), .clr_data_nack(clr_d),
    .ev_tx_started(ev_txs), .ev_rx_started(ev_rxs), .ev_last_tx(ev_ltx),
    .ev_last_rx(ev_lrx), .ev_suspended(ev_susp), .ev_stopped(ev_stop),
    .ev_error(ev_err), .addr_nack_flag(fa), .data_nack_flag(fd),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .cmd_nack_out(cmd_nack_out), .eng_done(eng_done), .eng_nack(eng_nack),
    .eng_rdata(eng_rdata), .hold_scl(hold_scl),
    .buf_rd_idx(buf_rd_idx), .buf_rd_data(buf_rd_data),
    .buf_wr_en(buf_wr_en), .buf_wr_idx(buf_wr_idx), .buf_wr_data(buf_wr_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign buf_rd_data = 8'h10 + buf_rd_idx;

  // engine and slave model plus logging
  logic log_clr;
  logic nack_addr;
  int   nack_data_idx;
  int   log_n, eng_cnt, done_n, wr_idx, rd_idx;
  logic addr_next, pend_nack;
  logic [7:0] pend_rdata;
  logic [1:0] op_log [64];
  logic [7:0] byte_log [64];
  logic       ack_log [64];
  logic [7:0] rx_mem [16];
  int c_txs, c_rxs, c_ltx, c_lrx, c_susp, c_stop, c_err, d_at_ltx, d_at_lrx;

  always @(posedge clk) begin
    if (log_clr) begin
      log_n <= 0; eng_cnt <= 0; done_n <= 0; wr_idx <= 0; rd_idx <= 0;
      addr_next <= 1'b0; eng_done <= 1'b0; eng_nack <= 1'b0; eng_rdata <= 8'h00;
      c_txs <= 0; c_rxs <= 0; c_ltx <= 0; c_lrx <= 0; c_susp <= 0;
      c_stop <= 0; c_err <= 0; d_at_ltx <= -1; d_at_lrx <= -1;
    end else begin
      eng_done <= 1'b0;
      eng_nack <= 1'b0;
      if (eng_done) done_n <= done_n + 1;
      if (eng_cnt > 0) begin
        eng_cnt <= eng_cnt - 1;
        if (eng_cnt == 1) begin
          eng_done  <= 1'b1;
          eng_nack  <= pend_nack;
          eng_rdata <= pend_rdata;
        end
      end
      if (cmd_valid) begin
        op_log[log_n]   <= cmd_op;
        byte_log[log_n] <= cmd_byte;
        ack_log[log_n]  <= cmd_nack_out;
        log_n   <= log_n + 1;
        eng_cnt <= 3;
        pend_nack <= 1'b0;
        if (cmd_op == 2'(OPS)) begin
          addr_next <= 1'b1; wr_idx <= 0; rd_idx <= 0;
        end else if (cmd_op == 2'(OPW)) begin
          if (addr_next) begin
            addr_next <= 1'b0;
            pend_nack <= nack_addr;
          end else begin
            pend_nack <= (wr_idx == nack_data_idx);
            wr_idx <= wr_idx + 1;
          end
        end else if (cmd_op == 2'(OPR)) begin
          pend_rdata <= 8'hA0 + 8'(rd_idx);
          rd_idx <= rd_idx + 1;
        end
      end
      if (buf_wr_en) rx_mem[buf_wr_idx[3:0]] <= buf_wr_data;
      if (ev_txs) c_txs <= c_txs + 1;
      if (ev_rxs) c_rxs <= c_rxs + 1;
      if (ev_ltx) begin c_ltx <= c_ltx + 1; d_at_ltx <= done_n; end
      if (ev_lrx) begin c_lrx <= c_lrx + 1; d_at_lrx <= done_n; end
      if (ev_susp) c_susp <= c_susp + 1;
      if (ev_stop) c_stop <= c_stop + 1;
      if (ev_err)  c_err  <= c_err + 1;
    end
  end

  int checks, errors;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [4:0] m);
    @(negedge clk);
    {t_res, t_susp, t_stop, t_srx, t_stx} = m;
    @(negedge clk);
    {t_res, t_susp, t_stop, t_srx, t_stx} = 5'b0;
  endtask

  task automatic clear_log();
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_stop();
    int g = 0;
    while (c_stop == 0 && g < 2000) begin @(negedge clk); g++; end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    checks = 0; errors = 0;
    {t_res, t_susp, t_stop, t_srx, t_stx} = 5'b0;
    clr_a = 0; clr_d = 0; log_clr = 1'b1;
    cfg_addr = TADDR; cfg_shorts = 0; tx_limit = 1; rx_limit = 1;
    nack_addr = 0; nack_data_idx = -1;
    rst_n = 0;
    idle(4);
    rst_n = 1;
    idle(2);
    log_clr = 1'b0;

    // R11 reset state
    chk("R11 events", int'({ev_txs, ev_rxs, ev_ltx, ev_lrx, ev_susp, ev_stop, ev_err}), 0);
    chk("R11 cmd_valid", int'(cmd_valid), 0);
    chk("R11 hold_scl", int'(hold_scl), 0);
    chk("R11 flags", int'({fa, fd}), 0);

    // table-driven transfers with a stop shortcut
    for (int v = 0; v < 4; v++) begin
      logic rx;
      int lim;
      rx  = VEC[v][15];
      lim = int'(VEC[v][14:8]);
      clear_log();
      cfg_shorts = VEC[v][4:0];
      tx_limit = 8'(lim); rx_limit = 8'(lim);
      pulse(rx ? 5'b00010 : 5'b00001);
      wait_stop();
      idle(3);
      chk("R1 log length", log_n, lim + 3);
      chk("R1 first op START", int'(op_log[0]), OPS);
      chk("R1 address byte", int'(byte_log[1]), int'({TADDR, rx}));
      chk("R1 started event", rx ? c_rxs : c_txs, 1);
      for (int i = 0; i < lim; i++) begin
        chk(rx ? "R4 read op" : "R2 write op", int'(op_log[2+i]), rx ? OPR : OPW);
        if (rx) begin
          chk("R4 ack bit", int'(ack_log[2+i]), (i == lim-1) ? 1 : 0);
          chk("R4 stored byte", int'(rx_mem[i]), 'hA0 + i);
        end else begin
          chk("R2 sent byte", int'(byte_log[2+i]), 'h10 + i);
        end
      end
      if (rx) begin
        chk("R3 last_rx count", c_lrx, 1);
        chk("R3 last_rx timing", d_at_lrx, lim + 1);
      end else begin
        chk("R2 last_tx count", c_ltx, 1);
        chk("R2 last_tx timing", d_at_ltx, lim + 1);
      end
      chk("R8 stop shortcut STOP op", int'(op_log[lim+2]), OPP);
      chk("R5 stopped", c_stop, 1);
    end

    // R5 no self stop
    clear_log();
    cfg_shorts = 0; tx_limit = 2;
    pulse(5'b00001);
    idle(60);
    chk("R5 no stopped", c_stop, 0);
    chk("R5 hold_scl", int'(hold_scl), 1);
    chk("R5 no STOP issued", log_n, 4);
    pulse(5'b00100);
    wait_stop();
    idle(2);
    chk("R5 STOP after task", int'(op_log[4]), OPP);
    chk("R5 stopped after task", c_stop, 1);

    // R9 address NACK
    clear_log();
    nack_addr = 1; cfg_shorts = 5'b00100; tx_limit = 2;
    pulse(5'b00001);
    idle(40);
    chk("R9 addr error", c_err, 1);
    chk("R9 addr flag", int'(fa), 1);
    chk("R9 data flag clear", int'(fd), 0);
    chk("R9 no data after addr nack", log_n, 2);
    pulse(5'b00100);
    wait_stop();
    idle(2);
    chk("R9 STOP after nack", int'(op_log[2]), OPP);
    @(negedge clk); clr_a = 1; @(negedge clk); clr_a = 0; @(negedge clk);
    chk("R9 addr flag w1c", int'(fa), 0);
    nack_addr = 0;

    // R9 data NACK
    clear_log();
    nack_data_idx = 0; cfg_shorts = 0; tx_limit = 3;
    pulse(5'b00001);
    idle(40);
    chk("R9 data error", c_err, 1);
    chk("R9 data flag", int'(fd), 1);
    chk("R9 halted after data nack", log_n, 3);
    pulse(5'b00100);
    wait_stop();
    @(negedge clk); clr_d = 1; @(negedge clk); clr_d = 0; @(negedge clk);
    chk("R9 data flag w1c", int'(fd), 0);
    nack_data_idx = -1;

    // R6 / R7 suspend, ignored stop, resume
    clear_log();
    cfg_shorts = 5'b00100; tx_limit = 3;
    pulse(5'b00001);
    begin
      int g = 0;
      while (log_n < 3 && g < 200) begin @(negedge clk); g++; end
    end
    pulse(5'b01000);
    idle(30);
    chk("R6 suspended event", c_susp, 1);
    chk("R6 hold while suspended", int'(hold_scl), 1);
    chk("R6 byte finished, none new", log_n, 3);
    pulse(5'b00100);
    idle(20);
    chk("R7 stop ignored no STOP", log_n, 3);
    chk("R7 stop ignored no event", c_stop, 0);
    pulse(5'b10000);
    wait_stop();
    idle(2);
    chk("R6 resume continues write", int'(op_log[3]), OPW);
    chk("R7 all bytes then STOP", log_n, 6);
    chk("R7 stopped once", c_stop, 1);

    // R8 repeated start write then read
    clear_log();
    cfg_shorts = 5'b10001; tx_limit = 1; rx_limit = 2;
    pulse(5'b00001);
    wait_stop();
    idle(2);
    chk("R8 log length", log_n, 8);
    chk("R8 repeated START", int'(op_log[3]), OPS);
    chk("R8 read address", int'(byte_log[4]), int'({TADDR, 1'b1}));
    chk("R8 tx started", c_txs, 1);
    chk("R8 rx started", c_rxs, 1);
    chk("R8 final NACK", int'(ack_log[6]), 1);

    // R10 start ignored alongside stop
    clear_log();
    cfg_shorts = 0; tx_limit = 1;
    pulse(5'b00001);
    idle(30);
    pulse(5'b00110);
    wait_stop();
    idle(10);
    chk("R10 no repeated start", log_n, 4);
    chk("R10 no rx started", c_rxs, 0);
    chk("R10 back to idle", int'(hold_scl), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule